// File: doc/BRIEF.md
# APB Dual Timer Register Front End

This block is an APB slave that places two identical down-counting timer units behind a single 4 KB register window. Every transfer completes in its access phase without wait states. The block steers each write to the addressed timer, multiplexes read data back, and reports each timer's interrupt flag both raw and gated by that timer's enable bit. It also serves fixed identification bytes near the top of the window.

Each timer unit is instantiated as its own submodule. A unit holds a reload register, a count register and a control byte. It counts at the bus clock divided by 1, 16 or 256. It can run 16 or 32 bits wide, free-running or periodic, and continuously or once. A test register can take over both interrupt outputs, so that interrupt wiring can be exercised without waiting for the counters. A third output is the OR of the two per-timer lines.

Software selects a timer with offset bit 5 and a register within that timer with offset bits 4:2. It writes the reload value and the control byte, then services interrupts by reading the status registers and writing the clear register.

Top module: `apb_twin_timer`

## Requirements
- R1: `pready` is always 1 and `pslverr` is always 0. A write takes effect on the clock edge of its access phase (`psel`, `penable` and `pwrite` all high). Read data is valid during the access phase.
- R2: Below 0x40 the offset splits into a timer select in bit 5 (0 selects timer A, 1 selects timer B) and a register index in bits 4:2. The indices are: 0 reload, 1 count, 2 control, 3 interrupt clear, 4 raw status, 5 masked status, 6 background reload. Index 6 reads back the reload value. Accesses to one timer leave the other timer unchanged.
- R3: After reset, for each timer: control reads 0x20, reload reads 0, count reads 0xFFFFFFFF and the raw flag is 0. Both test registers are 0 and all three interrupt outputs are low.
- R4: A write to index 0 loads the written word into both reload and count. A write to index 6 changes only reload.
- R5: The control byte has these fields: bit 0 one-shot, bit 1 32-bit width, bits 3:2 prescale select, bit 5 interrupt enable, bit 6 periodic, bit 7 run. A write keeps only these bits (mask 0xEF).
- R6: While running, the count steps once every 1, 16 or 256 clocks for prescale codes 0, 1, and 2 or 3. The first step comes that many clocks after the control write. A step from 1 to 0 sets the raw flag. A step taken at 0 reloads the count: from reload in periodic mode, or to all ones in free-running mode. In one-shot mode the count stays at 0 instead.
- R7: When bit 1 of control is 0, only count bits 15:0 step and are compared with 0 and 1. Bits 31:16 keep their value.
- R8: Writing any value to index 3 clears the raw flag. If the flag is set on the same edge as the clear, the set takes effect.
- R9: Index 4 reads the raw flag in bit 0. Index 5 reads the raw flag ANDed with the interrupt-enable bit. With the enable bit clear, the timer's interrupt line stays low.
- R10: Offset 0xF00 bit 0 enables test mode. In test mode, bits 0 and 1 of offset 0xF04 drive the timer A and timer B interrupt lines. Writes keep only those bits. 0xF00 reads back its bit, and 0xF04 reads as 0.
- R11: The combined interrupt line is the OR of the two per-timer lines, taken after the test-mode selection.
- R12: The interrupt lines are registered. They change one clock after the edge that sets or clears the raw flag, or that writes a test register.
- R13: Identification bytes, zero-extended to 32 bits, read as follows. 0xFD0 to 0xFDC: 0x04, 0x00, 0x00, 0x00. 0xFE0 to 0xFEC: 0x23, 0xB8, 0x1B, 0x00. 0xFF0 to 0xFFC: 0x0D, 0xF0, 0x05, 0xB1.
- R14: Any other offset, including index 7 of a timer and the range 0x40 to 0xEFF, reads as 0 and ignores writes. The identification bytes ignore writes too.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Bus and counting clock |
| presetn | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 10 | Word address, byte offset bits 11:2 |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Transfer done, tied high |
| pslverr | output | 1 | Error response, tied low |
| irq_a | output | 1 | Timer A interrupt |
| irq_b | output | 1 | Timer B interrupt |
| irq_any | output | 1 | OR of both timer interrupts |

## Verification
Two functions can fall on the same clock edge: a counter stepping from 1 to 0, which sets the raw flag, and a bus write to the interrupt clear register, which clears it. The bench loads a known count into a running timer at divide-by-1 and times the clear write so that its access edge is exactly the expiry edge. It then requires the timer's interrupt line to be high two clocks later, which shows that the set took effect. The same sequence also checks that the line is still low one clock after expiry, as the registered output requires.

// File: rtl/twin_timer_pkg.sv
// Package: twin_timer_pkg
// Shared constants for the dual timer front end: register indices within a
// timer slot, control bit positions, word addresses of the test registers,
// decode regions and the identification byte table.
// Assumes byte offsets below 0x40 belong to the two timer slots.
package twin_timer_pkg;

    localparam int NUM_T = 2;

    localparam logic [2:0] RG_LOAD   = 3'd0;
    localparam logic [2:0] RG_VALUE  = 3'd1;
    localparam logic [2:0] RG_CTRL   = 3'd2;
    localparam logic [2:0] RG_INTCLR = 3'd3;
    localparam logic [2:0] RG_RIS    = 3'd4;
    localparam logic [2:0] RG_MIS    = 3'd5;
    localparam logic [2:0] RG_BGLOAD = 3'd6;

    localparam int CB_ONESHOT  = 0;
    localparam int CB_WIDE     = 1;
    localparam int CB_PRE_LO   = 2;
    localparam int CB_INTEN    = 5;
    localparam int CB_PERIODIC = 6;
    localparam int CB_RUN      = 7;

    localparam logic [7:0] CTRL_KEEP = 8'hEF;
    localparam logic [7:0] CTRL_RST  = 8'h20;

    localparam logic [9:0] WA_TEST_CTL = 10'h3C0;
    localparam logic [9:0] WA_TEST_OUT = 10'h3C1;

    typedef enum logic [2:0] {
        RGN_NONE,
        RGN_TIMER,
        RGN_TCTL,
        RGN_TOUT,
        RGN_IDENT
    } region_e;

    // Identification byte for word index 0..11 counted from offset 0xFD0.
    function automatic logic [7:0] ident_byte(input logic [3:0] idx);
        logic [7:0] b;
        case (idx)
            4'd0:    b = 8'h04;
            4'd4:    b = 8'h23;
            4'd5:    b = 8'hB8;
            4'd6:    b = 8'h1B;
            4'd8:    b = 8'h0D;
            4'd9:    b = 8'hF0;
            4'd10:   b = 8'h05;
            4'd11:   b = 8'hB1;
            default: b = 8'h00;
        endcase
        return b;
    endfunction

endpackage

// File: rtl/twin_timer_decode.sv
// Module: twin_timer_decode
// Decodes an APB word address into a region, a timer select, a register
// index and an identification index. Produces one write strobe per register
// kind and timer, plus the test register strobes.
// Assumes a 4 KB window (12 byte-address bits) and exactly two timer slots.
module twin_timer_decode
    import twin_timer_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:2] waddr,
    output region_e           region,
    output logic              tsel,
    output logic [2:0]        treg,
    output logic [3:0]        id_idx,
    output logic [NUM_T-1:0]  wr_load,
    output logic [NUM_T-1:0]  wr_bgload,
    output logic [NUM_T-1:0]  wr_ctrl,
    output logic [NUM_T-1:0]  wr_clr,
    output logic              wr_tctl,
    output logic              wr_tout
);

    logic wr_fire;
    logic in_timer;
    logic in_ident;

    assign wr_fire  = psel && penable && pwrite;
    assign tsel     = waddr[5];
    assign treg     = waddr[4:2];
    assign in_timer = (waddr[ADDR_W-1:6] == '0) && (waddr[4:2] != 3'd7);
    assign in_ident = (waddr[ADDR_W-1:6] == '1) && (waddr[5:4] != 2'd0);
    assign id_idx   = {waddr[5:4] - 2'd1, waddr[3:2]};

    // Region select from the word address.
    always_comb begin
        region = RGN_NONE;
        if (in_timer)
            region = RGN_TIMER;
        else if (waddr == WA_TEST_CTL)
            region = RGN_TCTL;
        else if (waddr == WA_TEST_OUT)
            region = RGN_TOUT;
        else if (in_ident)
            region = RGN_IDENT;
    end

    // Per-timer write strobes, one set per slot.
    for (genvar t = 0; t < NUM_T; t++) begin : g_strb
        logic hit;
        assign hit          = wr_fire && (region == RGN_TIMER) && (tsel == 1'(t));
        assign wr_load[t]   = hit && (treg == RG_LOAD);
        assign wr_bgload[t] = hit && (treg == RG_BGLOAD);
        assign wr_ctrl[t]   = hit && (treg == RG_CTRL);
        assign wr_clr[t]    = hit && (treg == RG_INTCLR);
    end

    assign wr_tctl = wr_fire && (region == RGN_TCTL);
    assign wr_tout = wr_fire && (region == RGN_TOUT);

endmodule

// File: rtl/twin_timer_unit.sv
// Module: twin_timer_unit
// One down-counting timer: reload and count registers, control byte,
// prescaler and raw interrupt flag. Counts in pclk cycles, divided by the
// prescale setting. In narrow mode only the low half of the count moves.
// Assumes at most one register write strobe per cycle.
module twin_timer_unit
    import twin_timer_pkg::*;
#(
    parameter int DATA_W       = 32,
    parameter int HALF_W       = 16,
    parameter int PRE_MID_LOG2 = 4,
    parameter int PRE_HI_LOG2  = 8
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              wr_load,
    input  logic              wr_bgload,
    input  logic              wr_ctrl,
    input  logic              wr_clr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] load_q,
    output logic [DATA_W-1:0] value_q,
    output logic [7:0]        ctrl_q,
    output logic              raw_q,
    output logic              expire,
    output logic              inten
);

    localparam int UPPER_W = DATA_W - HALF_W;
    localparam logic [PRE_HI_LOG2-1:0] MASK_MID = PRE_HI_LOG2'((1 << PRE_MID_LOG2) - 1);
    localparam logic [PRE_HI_LOG2-1:0] MASK_HI  = '1;

    logic [PRE_HI_LOG2-1:0] pre_cnt;
    logic [PRE_HI_LOG2-1:0] pre_mask;
    logic                   run;
    logic                   wide;
    logic                   periodic;
    logic                   oneshot;
    logic                   tick;
    logic                   at_zero;
    logic                   at_one;
    logic [DATA_W-1:0]      cur_eff;
    logic [DATA_W-1:0]      reload_src;
    logic [DATA_W-1:0]      value_nxt;

    assign run      = ctrl_q[CB_RUN];
    assign wide     = ctrl_q[CB_WIDE];
    assign periodic = ctrl_q[CB_PERIODIC];
    assign oneshot  = ctrl_q[CB_ONESHOT];
    assign inten    = ctrl_q[CB_INTEN];

    // Prescale mask from the two select bits; code 3 behaves as code 2.
    always_comb begin
        case (ctrl_q[CB_PRE_LO +: 2])
            2'd0:    pre_mask = '0;
            2'd1:    pre_mask = MASK_MID;
            default: pre_mask = MASK_HI;
        endcase
    end

    assign tick       = run && ((pre_cnt & pre_mask) == pre_mask);
    assign cur_eff    = wide ? value_q : {{UPPER_W{1'b0}}, value_q[HALF_W-1:0]};
    assign at_zero    = (cur_eff == '0);
    assign at_one     = (cur_eff == DATA_W'(1));
    assign reload_src = periodic ? load_q : '1;
    assign expire     = tick && at_one && !wr_load;

    // Next count for one step: decrement, or reload/hold at zero.
    always_comb begin
        if (at_zero) begin
            if (oneshot)
                value_nxt = value_q;
            else if (wide)
                value_nxt = reload_src;
            else
                value_nxt = {value_q[DATA_W-1:HALF_W], reload_src[HALF_W-1:0]};
        end else if (wide) begin
            value_nxt = value_q - DATA_W'(1);
        end else begin
            value_nxt = {value_q[DATA_W-1:HALF_W], value_q[HALF_W-1:0] - HALF_W'(1)};
        end
    end

    // Prescaler: restarts on a control write and while stopped.
    always_ff @(posedge pclk) begin
        if (!presetn)
            pre_cnt <= '0;
        else if (wr_ctrl || !run)
            pre_cnt <= '0;
        else
            pre_cnt <= pre_cnt + PRE_HI_LOG2'(1);
    end

    // Control byte, reduced to its defined bits.
    always_ff @(posedge pclk) begin
        if (!presetn)
            ctrl_q <= CTRL_RST;
        else if (wr_ctrl)
            ctrl_q <= wdata[7:0] & CTRL_KEEP;
    end

    // Reload register, written by either load register.
    always_ff @(posedge pclk) begin
        if (!presetn)
            load_q <= '0;
        else if (wr_load || wr_bgload)
            load_q <= wdata;
    end

    // Count register: a load write overrides a step.
    always_ff @(posedge pclk) begin
        if (!presetn)
            value_q <= '1;
        else if (wr_load)
            value_q <= wdata;
        else if (tick)
            value_q <= value_nxt;
    end

    // Raw interrupt flag: expiry has priority over a clear.
    always_ff @(posedge pclk) begin
        if (!presetn)
            raw_q <= 1'b0;
        else if (expire)
            raw_q <= 1'b1;
        else if (wr_clr)
            raw_q <= 1'b0;
    end

endmodule

// File: rtl/twin_timer_irq.sv
// Module: twin_timer_irq
// Holds the test-mode control and test output registers and drives the
// registered interrupt lines: per timer, either raw AND enable or the test
// bit, plus their OR.
// Assumes the raw flags and enables come from registers in the same domain.
module twin_timer_irq
    import twin_timer_pkg::*;
(
    input  logic             pclk,
    input  logic             presetn,
    input  logic             wr_tctl,
    input  logic             wr_tout,
    input  logic [NUM_T-1:0] wbits,
    input  logic [NUM_T-1:0] raw,
    input  logic [NUM_T-1:0] inten,
    output logic             itcr_q,
    output logic [NUM_T-1:0] itop_q,
    output logic [NUM_T-1:0] irq_q,
    output logic             any_q
);

    logic [NUM_T-1:0] irq_nxt;

    assign irq_nxt = itcr_q ? itop_q : (raw & inten);

    // Test-mode enable bit.
    always_ff @(posedge pclk) begin
        if (!presetn)
            itcr_q <= 1'b0;
        else if (wr_tctl)
            itcr_q <= wbits[0];
    end

    // Test output bits, one per timer line.
    always_ff @(posedge pclk) begin
        if (!presetn)
            itop_q <= '0;
        else if (wr_tout)
            itop_q <= wbits;
    end

    // Registered interrupt lines and their OR.
    always_ff @(posedge pclk) begin
        if (!presetn) begin
            irq_q <= '0;
            any_q <= 1'b0;
        end else begin
            irq_q <= irq_nxt;
            any_q <= |irq_nxt;
        end
    end

endmodule

// File: rtl/apb_twin_timer.sv
// Module: apb_twin_timer
// APB slave front end for two timer units in a 4 KB window. Decodes each
// access, drives the timer units and the interrupt stage, and multiplexes
// read data. Transfers need no wait states and never report an error.
// Assumes pclk also clocks the counters (no separate timer clock).
module apb_twin_timer
    import twin_timer_pkg::*;
#(
    parameter int ADDR_W       = 12,
    parameter int DATA_W       = 32,
    parameter int HALF_W       = 16,
    parameter int PRE_MID_LOG2 = 4,
    parameter int PRE_HI_LOG2  = 8
) (
    input  logic              pclk,
    input  logic              presetn,
    input  logic              psel,
    input  logic              penable,
    input  logic              pwrite,
    input  logic [ADDR_W-1:2] paddr,
    input  logic [DATA_W-1:0] pwdata,
    output logic [DATA_W-1:0] prdata,
    output logic              pready,
    output logic              pslverr,
    output logic              irq_a,
    output logic              irq_b,
    output logic              irq_any
);

    region_e           region;
    logic              tsel;
    logic [2:0]        treg;
    logic [3:0]        id_idx;
    logic [NUM_T-1:0]  wr_load;
    logic [NUM_T-1:0]  wr_bgload;
    logic [NUM_T-1:0]  wr_ctrl;
    logic [NUM_T-1:0]  clr_vec;
    logic              wr_tctl;
    logic              wr_tout;

    logic [DATA_W-1:0] load_arr  [NUM_T];
    logic [DATA_W-1:0] value_arr [NUM_T];
    logic [7:0]        ctrl_arr  [NUM_T];
    logic [NUM_T-1:0]  raw_vec;
    logic [NUM_T-1:0]  expire_vec;
    logic [NUM_T-1:0]  inten_vec;

    logic              itcr_q;
    logic [NUM_T-1:0]  itop_q;
    logic [NUM_T-1:0]  irq_q;
    logic              any_q;
    logic [DATA_W-1:0] rd_mux;

    twin_timer_decode #(
        .ADDR_W (ADDR_W)
    ) u_decode (
        .psel      (psel),
        .penable   (penable),
        .pwrite    (pwrite),
        .waddr     (paddr),
        .region    (region),
        .tsel      (tsel),
        .treg      (treg),
        .id_idx    (id_idx),
        .wr_load   (wr_load),
        .wr_bgload (wr_bgload),
        .wr_ctrl   (wr_ctrl),
        .wr_clr    (clr_vec),
        .wr_tctl   (wr_tctl),
        .wr_tout   (wr_tout)
    );

    for (genvar t = 0; t < NUM_T; t++) begin : g_unit
        twin_timer_unit #(
            .DATA_W       (DATA_W),
            .HALF_W       (HALF_W),
            .PRE_MID_LOG2 (PRE_MID_LOG2),
            .PRE_HI_LOG2  (PRE_HI_LOG2)
        ) u_unit (
            .pclk      (pclk),
            .presetn   (presetn),
            .wr_load   (wr_load[t]),
            .wr_bgload (wr_bgload[t]),
            .wr_ctrl   (wr_ctrl[t]),
            .wr_clr    (clr_vec[t]),
            .wdata     (pwdata),
            .load_q    (load_arr[t]),
            .value_q   (value_arr[t]),
            .ctrl_q    (ctrl_arr[t]),
            .raw_q     (raw_vec[t]),
            .expire    (expire_vec[t]),
            .inten     (inten_vec[t])
        );
    end

    twin_timer_irq u_irq (
        .pclk    (pclk),
        .presetn (presetn),
        .wr_tctl (wr_tctl),
        .wr_tout (wr_tout),
        .wbits   (pwdata[NUM_T-1:0]),
        .raw     (raw_vec),
        .inten   (inten_vec),
        .itcr_q  (itcr_q),
        .itop_q  (itop_q),
        .irq_q   (irq_q),
        .any_q   (any_q)
    );

    // Read data selection by region and register index.
    always_comb begin
        rd_mux = '0;
        case (region)
            RGN_TIMER: begin
                case (treg)
                    RG_LOAD, RG_BGLOAD: rd_mux = load_arr[tsel];
                    RG_VALUE:           rd_mux = value_arr[tsel];
                    RG_CTRL:            rd_mux = DATA_W'(ctrl_arr[tsel]);
                    RG_RIS:             rd_mux = DATA_W'(raw_vec[tsel]);
                    RG_MIS:             rd_mux = DATA_W'(raw_vec[tsel] & inten_vec[tsel]);
                    default:            rd_mux = '0;
                endcase
            end
            RGN_TCTL:  rd_mux = DATA_W'(itcr_q);
            RGN_IDENT: rd_mux = DATA_W'(ident_byte(id_idx));
            default:   rd_mux = '0;
        endcase
    end

    assign prdata  = psel ? rd_mux : '0;
    assign pready  = 1'b1;
    assign pslverr = 1'b0;
    assign irq_a   = irq_q[0];
    assign irq_b   = irq_q[1];
    assign irq_any = any_q;

endmodule

// File: rtl/apb_twin_timer_chk.sv
// Module: apb_twin_timer_chk
// Property checker for apb_twin_timer, attached by the bind below. Relates
// the interrupt outputs to raw flags, enables, test registers and write
// strobes over time.
// Assumes synchronous active-low reset on presetn.
module apb_twin_timer_chk (
    input logic       pclk,
    input logic       presetn,
    input logic       irq_a,
    input logic       irq_b,
    input logic       irq_any,
    input logic       itcr_q,
    input logic [1:0] itop_q,
    input logic [1:0] raw_vec,
    input logic [1:0] inten_vec,
    input logic [1:0] clr_vec,
    input logic [1:0] expire_vec
);

    // R8: an expiry always leaves the raw flag set, even with a clear.
    p_set_wins_r8: assert property (@(posedge pclk) disable iff (!presetn)
        expire_vec[0] |=> raw_vec[0]);

    // R8: a clear without an expiry drops the raw flag.
    p_clear_r8: assert property (@(posedge pclk) disable iff (!presetn)
        (clr_vec[1] && !expire_vec[1]) |=> !raw_vec[1]);

    // R12: an enabled raw flag outside test mode raises the line a cycle later.
    p_irq_late_r12: assert property (@(posedge pclk) disable iff (!presetn)
        (!itcr_q && raw_vec[0] && inten_vec[0]) |=> irq_a);

    // R9: without a raw flag or an enable, the line stays low outside test mode.
    p_irq_mask_r9: assert property (@(posedge pclk) disable iff (!presetn)
        (!itcr_q && !(raw_vec[1] && inten_vec[1])) |=> !irq_b);

    // R10: in test mode both lines follow the test output bits.
    p_test_drive_r10: assert property (@(posedge pclk) disable iff (!presetn)
        itcr_q |=> ({irq_b, irq_a} == $past(itop_q)));

    // R11: the combined line matches the OR of the per-timer lines.
    p_any_or_r11: assert property (@(posedge pclk) disable iff (!presetn)
        irq_any == (irq_a || irq_b));

endmodule

bind apb_twin_timer apb_twin_timer_chk u_chk (
    .pclk       (pclk),
    .presetn    (presetn),
    .irq_a      (irq_a),
    .irq_b      (irq_b),
    .irq_any    (irq_any),
    .itcr_q     (itcr_q),
    .itop_q     (itop_q),
    .raw_vec    (raw_vec),
    .inten_vec  (inten_vec),
    .clr_vec    (clr_vec),
    .expire_vec (expire_vec)
);

// File: tb/apb_twin_timer_tb.sv
// Directed bench for apb_twin_timer: one task per scenario, each checking
// its own results through the APB port and the interrupt lines.
module apb_twin_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic        psel = 1'b0;
    logic        penable = 1'b0;
    logic        pwrite = 1'b0;
    logic [11:2] paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready;
    logic        pslverr;
    logic        irq_a;
    logic        irq_b;
    logic        irq_any;

    int n_chk = 0;
    int n_err = 0;
    bit done  = 1'b0;

    apb_twin_timer u_dut (
        .pclk    (pclk),
        .presetn (presetn),
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .prdata  (prdata),
        .pready  (pready),
        .pslverr (pslverr),
        .irq_a   (irq_a),
        .irq_b   (irq_b),
        .irq_any (irq_any)
    );

    always #(CLK_PERIOD / 2) pclk = ~pclk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge pclk);
    endtask

    // Write; the access edge is the second rising edge after the call.
    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a[11:2]; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic rd_chk(input string req, input logic [11:0] a, input logic [31:0] exp);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a[11:2];
        @(negedge pclk);
        penable = 1'b1;
        #1;
        check(req, prdata, exp);
        check("R1 pready", {31'b0, pready}, 32'd1);
        check("R1 pslverr", {31'b0, pslverr}, 32'd0);
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic irq_chk(input string req, input logic a, input logic b, input logic any);
        check({req, " irq_a"}, {31'b0, irq_a}, {31'b0, a});
        check({req, " irq_b"}, {31'b0, irq_b}, {31'b0, b});
        check({req, " irq_any"}, {31'b0, irq_any}, {31'b0, any});
    endtask

    task automatic t_reset();
        irq_chk("R3 reset", 1'b0, 1'b0, 1'b0);
        rd_chk("R3 ctrl A", 12'h008, 32'h20);
        rd_chk("R3 ctrl B", 12'h028, 32'h20);
        rd_chk("R3 value A", 12'h004, 32'hFFFF_FFFF);
        rd_chk("R3 load B", 12'h020, 32'h0);
        rd_chk("R3 raw A", 12'h010, 32'h0);
        rd_chk("R3 test ctl", 12'hF00, 32'h0);
    endtask

    task automatic t_map();
        wr(12'h000, 32'h1111_0000);
        wr(12'h020, 32'h2222_0000);
        rd_chk("R2 load A", 12'h000, 32'h1111_0000);
        rd_chk("R4 value A", 12'h004, 32'h1111_0000);
        rd_chk("R2 value B", 12'h024, 32'h2222_0000);
        rd_chk("R2 bgload A reads load", 12'h018, 32'h1111_0000);
    endtask

    task automatic t_unmapped();
        wr(12'h01C, 32'h0000_DEAD);
        wr(12'h048, 32'h0000_00FF);
        wr(12'hF08, 32'h3);
        wr(12'hFD0, 32'h55);
        idle(1);
        irq_chk("R14 no output change", 1'b0, 1'b0, 1'b0);
        rd_chk("R14 load A kept", 12'h000, 32'h1111_0000);
        rd_chk("R14 ctrl A kept", 12'h008, 32'h20);
        rd_chk("R14 test ctl kept", 12'hF00, 32'h0);
        rd_chk("R14 ident kept", 12'hFD0, 32'h04);
        rd_chk("R14 idx7", 12'h01C, 32'h0);
        rd_chk("R14 0x40", 12'h040, 32'h0);
        rd_chk("R14 0x3C", 12'h03C, 32'h0);
        rd_chk("R14 0xF08", 12'hF08, 32'h0);
        rd_chk("R14 0xFC0", 12'hFC0, 32'h0);
    endtask

    task automatic t_ident();
        rd_chk("R13 FD4", 12'hFD4, 32'h00);
        rd_chk("R13 FE0", 12'hFE0, 32'h23);
        rd_chk("R13 FE4", 12'hFE4, 32'hB8);
        rd_chk("R13 FE8", 12'hFE8, 32'h1B);
        rd_chk("R13 FEC", 12'hFEC, 32'h00);
        rd_chk("R13 FF0", 12'hFF0, 32'h0D);
        rd_chk("R13 FF4", 12'hFF4, 32'hF0);
        rd_chk("R13 FF8", 12'hFF8, 32'h05);
        rd_chk("R13 FFC", 12'hFFC, 32'hB1);
    endtask

    task automatic t_ctrl_mask();
        wr(12'h028, 32'hFFFF_FF7F);
        rd_chk("R5 ctrl keeps defined bits", 12'h028, 32'h6F);
        wr(12'h028, 32'h20);
    endtask

    task automatic t_reload();
        wr(12'h008, 32'h62);
        wr(12'h000, 32'd2);
        wr(12'h018, 32'd7);
        rd_chk("R4 bgload leaves count", 12'h004, 32'd2);
        rd_chk("R4 bgload sets reload", 12'h000, 32'd7);
        wr(12'h008, 32'hE2);   // run at edge E
        idle(2);
        wr(12'h008, 32'h62);   // stop at edge E+4
        rd_chk("R6 periodic reload then step", 12'h004, 32'd6);
        wr(12'h00C, 32'h0);
        rd_chk("R8 clear", 12'h010, 32'h0);
    endtask

    task automatic t_collide();
        wr(12'h008, 32'hE2);
        wr(12'h000, 32'd5);    // load at edge L, expiry at L+5
        idle(3);
        wr(12'h00C, 32'h0);    // clear at edge L+5
        check("R12 line still low after expiry edge", {31'b0, irq_a}, 32'd0);
        idle(1);
        check("R8 set wins over clear", {31'b0, irq_a}, 32'd1);
        wr(12'h008, 32'h62);
        rd_chk("R9 raw status", 12'h010, 32'd1);
        rd_chk("R9 masked status", 12'h014, 32'd1);
        wr(12'h00C, 32'h1234);
        rd_chk("R8 clear any value", 12'h010, 32'h0);
        check("R12 line drops", {31'b0, irq_a}, 32'd0);
    endtask

    task automatic t_oneshot();
        wr(12'h008, 32'h63);
        wr(12'h000, 32'd3);
        wr(12'h008, 32'hE3);
        idle(10);
        rd_chk("R6 one-shot holds zero", 12'h004, 32'd0);
        rd_chk("R6 one-shot expired", 12'h010, 32'd1);
        wr(12'h008, 32'hC3);
        rd_chk("R9 masked with enable off", 12'h014, 32'd0);
        rd_chk("R9 raw with enable off", 12'h010, 32'd1);
        check("R9 line low with enable off", {31'b0, irq_a}, 32'd0);
        wr(12'h00C, 32'h0);
        idle(5);
        rd_chk("R8 one-shot stays clear", 12'h010, 32'd0);
    endtask

    task automatic t_wide16();
        wr(12'h008, 32'h20);
        wr(12'h000, 32'h0001_0002);
        wr(12'h008, 32'hA0);   // run at E, expiry E+2, wrap E+3
        idle(1);
        wr(12'h008, 32'h20);   // stop at E+3
        rd_chk("R7 low half wraps, upper kept", 12'h004, 32'h0001_FFFF);
        rd_chk("R7 expiry at low half zero", 12'h010, 32'd1);
        check("R7 line high", {31'b0, irq_a}, 32'd1);
    endtask

    task automatic t_testmode();
        wr(12'hF00, 32'hFFFF_FFFF);
        check("R12 test ctl takes a cycle", {31'b0, irq_a}, 32'd1);
        idle(1);
        irq_chk("R10 override low", 1'b0, 1'b0, 1'b0);
        rd_chk("R10 test ctl readback", 12'hF00, 32'd1);
        wr(12'hF04, 32'hFFFF_FFFE);
        idle(1);
        irq_chk("R11 test B only", 1'b0, 1'b1, 1'b1);
        rd_chk("R10 test out reads zero", 12'hF04, 32'd0);
        wr(12'hF04, 32'h1);
        idle(1);
        irq_chk("R11 test A only", 1'b1, 1'b0, 1'b1);
        wr(12'hF04, 32'h0);
        wr(12'hF00, 32'h0);
        idle(1);
        irq_chk("R10 back to timer", 1'b1, 1'b0, 1'b1);
        wr(12'h00C, 32'h0);
        idle(1);
        irq_chk("R11 all low", 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_prescale();
        wr(12'h028, 32'h66);
        wr(12'h02C, 32'h0);
        wr(12'h020, 32'd3);
        wr(12'h028, 32'hE6);   // divide by 16, expiry at E+48
        idle(48);
        check("R6 div16 not yet", {31'b0, irq_b}, 32'd0);
        idle(1);
        irq_chk("R6 div16 expiry on B", 1'b0, 1'b1, 1'b1);
        wr(12'h028, 32'h6E);
        wr(12'h02C, 32'h0);
        wr(12'h020, 32'd1);
        wr(12'h028, 32'hEE);   // code 3 divides by 256, expiry at E+256
        idle(256);
        check("R6 div256 not yet", {31'b0, irq_b}, 32'd0);
        idle(1);
        irq_chk("R6 code 3 divides by 256", 1'b0, 1'b1, 1'b1);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge pclk);
        n_chk++;
        n_err++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
        @(negedge pclk);
        t_reset();
        t_map();
        t_unmapped();
        t_ident();
        t_ctrl_mask();
        t_reload();
        t_collide();
        t_oneshot();
        t_wide16();
        t_testmode();
        t_prescale();
        finish_run();
    end

endmodule